// File: doc/BRIEF.md
# Serial Flash Status and Write-Protection Gate

This block holds the status byte of a serial NOR flash and decides whether each decoded command may run. The byte carries a busy flag, a write-enable latch, a three-bit protect level, a status-lock bit and two bits that always read as zero. A command arrives as a one-cycle strobe with an operation code, a target address and, for a status write, a data byte. The block answers each strobe with exactly one accept pulse or one reject pulse.

Accepted status writes, page programs, sector erases and bulk erases raise busy. Busy stays high until the array sequencer returns a completion pulse. The outcome of a command depends on several things: the write-enable latch, the protect level compared with the target address, the write-protect pin together with the status-lock bit, and an OTP-mode flag that turns the status-lock bit into a permanent lock. The non-volatile protect level and lock bit come from a parameter at reset. This stands in for the stored value that the chip reloads at power-on.

Top module: `fstat_top`

## Requirements
- R1: On reset, status_o equals {NV_INIT[7], 2'b00, NV_INIT[4:2], 1'b0, 1'b0}. With the default NV_INIT of 0, status_o is 8'h00.
- R2: Status bit 1 is the write-enable latch. An accepted enable command (code 1) sets it and an accepted disable command (code 2) clears it. The change is visible in the cycle after the strobe.
- R3: While the write-enable latch is 0, a status write (code 3), page program (code 4), sector erase (code 5) or bulk erase (code 6) is rejected and busy stays 0.
- R4: Status bit 0 is busy. An accepted code 3 to 6 sets busy in the cycle after the strobe. A completion pulse while busy clears both busy and the write-enable latch in the next cycle. A completion pulse while idle has no effect.
- R5: While busy is 1, every command other than status read (code 0) is rejected. A status read is always accepted.
- R6: When an accepted status write completes, bits 4:2 of its data become the protect level at status bits 4:2, and data bit 7 becomes the status-lock bit at status bit 7. Status bits 6:5 always read 0, and data bits 6:5 and 1:0 are ignored.
- R7: Hardware-protected mode is active when status bit 7 is 1, wp_n is 0 and otp_mode is 0. In this mode a status write is rejected and the status byte is unchanged.
- R8: A protect level N from 1 to 6 protects the addresses at or above 2^ADDR_W − 2^(ADDR_W−(7−N)), and a level of 7 protects every address. A page program or sector erase that targets a protected address is rejected. Otherwise it is accepted.
- R9: A bulk erase is accepted only when the protect level is 0.
- R10: When otp_mode is 1 and status bit 7 is 1, codes 3 to 6 are all rejected, whatever the level of wp_n.
- R11: Any rejected command clears the write-enable latch in the next cycle.
- R12: Each strobe yields exactly one one-cycle pulse on accept_o or reject_o, in the cycle after the strobe. Code 7 is always rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_code | input | 3 | Operation: 0 read status, 1 enable, 2 disable, 3 status write, 4 page program, 5 sector erase, 6 bulk erase, 7 reserved |
| cmd_addr | input | ADDR_W | Target byte address for program and erase |
| wr_data | input | 8 | Data byte for status write |
| wp_n | input | 1 | Write-protect pin, low asserts protection |
| otp_mode | input | 1 | OTP mode flag, turns the lock bit into a permanent lock |
| done | input | 1 | Completion pulse from the array sequencer |
| status_o | output | 8 | Status byte readback |
| accept_o | output | 1 | Command accepted pulse |
| reject_o | output | 1 | Command rejected pulse |

## Verification
The accept or reject pulse and every status change caused by a strobe appear one cycle after the strobe edge. A completion pulse updates busy, the latch, the protect level and the lock bit one cycle later. The bench drives each strobe on a falling edge, removes it on the next falling edge and samples the response there. That falling edge lies half a period after the rising edge that registered the result. Before each new strobe, the bench also confirms that both response pulses have gone back to zero.

// File: rtl/fstat_pkg.sv
package fstat_pkg;

    localparam int BP_W    = 3;
    localparam int BP_FULL = (1 << BP_W) - 1;

    typedef enum logic [2:0] {
        OP_RDSR = 3'd0,
        OP_WREN = 3'd1,
        OP_WRDI = 3'd2,
        OP_WRSR = 3'd3,
        OP_PP   = 3'd4,
        OP_SE   = 3'd5,
        OP_BE   = 3'd6,
        OP_RSVD = 3'd7
    } op_e;

    typedef struct packed {
        logic            lock;
        logic [1:0]      rsvd;
        logic [BP_W-1:0] bp;
        logic            wel;
        logic            busy;
    } stat_t;

    function automatic logic needs_wel(op_e op);
        return (op == OP_WRSR) || (op == OP_PP) || (op == OP_SE) || (op == OP_BE);
    endfunction

endpackage

// File: rtl/fstat_range.sv
module fstat_range
    import fstat_pkg::*;
#(
    parameter int ADDR_W = 22
) (
    input  logic [BP_W-1:0]   bp,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    localparam int TOP_BITS = BP_FULL - 1;

    int k;

    always_comb begin
        k   = BP_FULL - int'(bp);
        hit = 1'b0;
        if (int'(bp) == BP_FULL) begin
            hit = 1'b1;
        end else if (bp != '0) begin
            hit = 1'b1;
            for (int i = 0; i < TOP_BITS; i++) begin
                if (i < k) hit = hit & addr[ADDR_W-1-i];
            end
        end
    end

    initial begin
        if (ADDR_W < TOP_BITS) $error("ADDR_W too small for protect decode");
    end
endmodule

// File: rtl/fstat_gate.sv
module fstat_gate
    import fstat_pkg::*;
#(
    parameter int ADDR_W = 22
) (
    input  op_e               op,
    input  logic [ADDR_W-1:0] addr,
    input  stat_t             st,
    input  logic              wp_n,
    input  logic              otp_mode,
    output logic              grant
);
    logic in_range;
    logic hw_lock;
    logic otp_lock;
    logic base_ok;

    fstat_range #(.ADDR_W(ADDR_W)) u_range (
        .bp   (st.bp),
        .addr (addr),
        .hit  (in_range)
    );

    always_comb begin
        hw_lock  = st.lock && !wp_n && !otp_mode;
        otp_lock = st.lock && otp_mode;
        base_ok  = !st.busy && st.wel && !otp_lock;
        unique case (op)
            OP_RDSR:       grant = 1'b1;
            OP_WREN,
            OP_WRDI:       grant = !st.busy;
            OP_WRSR:       grant = base_ok && !hw_lock;
            OP_PP, OP_SE:  grant = base_ok && !in_range;
            OP_BE:         grant = base_ok && (st.bp == '0);
            default:       grant = 1'b0;
        endcase
    end
endmodule

// File: rtl/fstat_regs.sv
module fstat_regs
    import fstat_pkg::*;
#(
    parameter logic [7:0] NV_INIT = 8'h00
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_valid,
    input  op_e        op,
    input  logic       grant,
    input  logic [7:0] wr_data,
    input  logic       done,
    output stat_t      st,
    output logic       accept_o,
    output logic       reject_o
);
    stat_t      nv_init_st;
    logic       pend_wr;
    logic [7:0] pend_data;

    assign nv_init_st = NV_INIT;

    always_ff @(posedge clk) begin
        if (rst) begin
            st.busy   <= 1'b0;
            st.wel    <= 1'b0;
            st.bp     <= nv_init_st.bp;
            st.lock   <= nv_init_st.lock;
            st.rsvd   <= 2'b00;
            pend_wr   <= 1'b0;
            pend_data <= 8'h00;
            accept_o  <= 1'b0;
            reject_o  <= 1'b0;
        end else begin
            accept_o <= cmd_valid && grant;
            reject_o <= cmd_valid && !grant;

            if (st.busy && done) begin
                st.busy <= 1'b0;
                st.wel  <= 1'b0;
                pend_wr <= 1'b0;
                if (pend_wr) begin
                    st.bp   <= pend_data[4:2];
                    st.lock <= pend_data[7];
                end
            end

            if (cmd_valid) begin
                if (grant) begin
                    case (op)
                        OP_WREN: st.wel <= 1'b1;
                        OP_WRDI: st.wel <= 1'b0;
                        OP_WRSR: begin
                            st.busy   <= 1'b1;
                            pend_wr   <= 1'b1;
                            pend_data <= wr_data;
                        end
                        OP_PP, OP_SE, OP_BE: st.busy <= 1'b1;
                        default: ;
                    endcase
                end else begin
                    st.wel <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/fstat_top.sv
module fstat_top
    import fstat_pkg::*;
#(
    parameter int         ADDR_W  = 22,
    parameter logic [7:0] NV_INIT = 8'h00
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_code,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [7:0]        wr_data,
    input  logic              wp_n,
    input  logic              otp_mode,
    input  logic              done,
    output logic [7:0]        status_o,
    output logic              accept_o,
    output logic              reject_o
);
    op_e   op;
    stat_t st;
    logic  grant;

    assign op       = op_e'(cmd_code);
    assign status_o = {st.lock, 2'b00, st.bp, st.wel, st.busy};

    fstat_gate #(.ADDR_W(ADDR_W)) u_gate (
        .op       (op),
        .addr     (cmd_addr),
        .st       (st),
        .wp_n     (wp_n),
        .otp_mode (otp_mode),
        .grant    (grant)
    );

    fstat_regs #(.NV_INIT(NV_INIT)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .op        (op),
        .grant     (grant),
        .wr_data   (wr_data),
        .done      (done),
        .st        (st),
        .accept_o  (accept_o),
        .reject_o  (reject_o)
    );
endmodule

// File: rtl/fstat_chk.sv
module fstat_chk (
    input logic       clk,
    input logic       rst,
    input logic       cmd_valid,
    input logic [2:0] cmd_code,
    input logic       wp_n,
    input logic       otp_mode,
    input logic       done,
    input logic [7:0] status_o,
    input logic       accept_o,
    input logic       reject_o
);
    // R12
    resp_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(accept_o && reject_o));

    // R12
    resp_follows_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> (accept_o || reject_o));

    // R12
    resp_needs_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        (accept_o || reject_o) |-> $past(cmd_valid));

    // R3
    no_wel_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !status_o[1] && cmd_code >= 3'd3 && cmd_code <= 3'd6) |=> reject_o);

    // R5
    busy_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && status_o[0] && cmd_code != 3'd0) |=> reject_o);

    // R4
    done_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (done && status_o[0]) |=> (!status_o[0] && !status_o[1]));

    // R7
    hw_protect_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_code == 3'd3 && status_o[7] && !wp_n && !otp_mode) |=> reject_o);

    // R9
    bulk_guard_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_code == 3'd6 && status_o[4:2] != 3'd0) |=> reject_o);

    // R11
    reject_clears_wel_chk: assert property (@(posedge clk) disable iff (rst)
        reject_o |-> !status_o[1]);
endmodule

bind fstat_top fstat_chk u_chk (.*);

// File: tb/sim_fstat_top.sv
module sim_fstat_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW   = 22;
    localparam int SIZE = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_valid = 1'b0;
    logic [2:0]    cmd_code = 3'd0;
    logic [AW-1:0] cmd_addr = '0;
    logic [7:0]    wr_data = 8'h00;
    logic          wp_n = 1'b1;
    logic          otp_mode = 1'b0;
    logic          done = 1'b0;
    logic [7:0]    status_o;
    logic          accept_o;
    logic          reject_o;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  acc, rej;

    always #(CLK_PERIOD/2) clk = ~clk;

    fstat_top #(.ADDR_W(AW), .NV_INIT(8'h00)) u0 (.*);

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] c, input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        chk(!accept_o && !reject_o, "R12 pulse width", {accept_o, reject_o}, 0);
        cmd_valid = 1'b1; cmd_code = c; cmd_addr = a; wr_data = d;
        @(negedge clk);
        cmd_valid = 1'b0;
        acc = accept_o; rej = reject_o;
    endtask

    task automatic finish_op();
        @(negedge clk); done = 1'b1;
        @(negedge clk); done = 1'b0;
    endtask

    task automatic set_status(input logic [7:0] d);
        issue(3'd1, '0, 8'h00);
        issue(3'd3, '0, d);
        finish_op();
    endtask

    function automatic bit prot(input int n, input int a);
        if (n == 7) return 1'b1;
        if (n == 0) return 1'b0;
        return a >= SIZE - (SIZE >> (7 - n));
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        chk(1'b0, "watchdog", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(status_o == 8'h00, "R1 reset status", status_o, 8'h00);

        issue(3'd1, '0, 8'h00);
        chk(acc && status_o == 8'h02, "R2 enable sets latch", status_o, 8'h02);
        issue(3'd2, '0, 8'h00);
        chk(acc && status_o == 8'h00, "R2 disable clears latch", status_o, 8'h00);

        for (int c = 3; c <= 6; c++) begin
            issue(3'(c), '0, 8'h00);
            chk(rej && status_o == 8'h00, "R3 rejected without latch", {acc, rej, status_o}, 8'h00 | (1 << 8));
        end

        issue(3'd1, '0, 8'h00);
        issue(3'd3, '0, 8'hFF);
        chk(acc && status_o == 8'h03, "R4 busy after status write", status_o, 8'h03);
        issue(3'd1, '0, 8'h00);
        chk(rej, "R5 enable rejected while busy", {acc, rej}, 1);
        issue(3'd4, '0, 8'h00);
        chk(rej, "R5 program rejected while busy", {acc, rej}, 1);
        issue(3'd0, '0, 8'h00);
        chk(acc && status_o == 8'h01, "R5 read accepted while busy", status_o, 8'h01);
        finish_op();
        chk(status_o == 8'h9C, "R6 status write applied, reserved zero", status_o, 8'h9C);

        wp_n = 1'b0;
        issue(3'd1, '0, 8'h00);
        issue(3'd3, '0, 8'h00);
        chk(rej && status_o == 8'h9C, "R7 status write blocked, R11 latch cleared", status_o, 8'h9C);
        wp_n = 1'b1;
        set_status(8'h00);
        chk(status_o == 8'h00, "R7 status write allowed with pin high", status_o, 8'h00);

        for (int n = 0; n < 8; n++) begin
            int bnd;
            int addrs[4];
            set_status(8'(n << 2));
            chk(status_o == 8'(n << 2), "R6 protect level loaded", status_o, n << 2);
            bnd = (n >= 1 && n <= 6) ? SIZE - (SIZE >> (7 - n)) : SIZE / 2;
            addrs[0] = 0; addrs[1] = SIZE - 1; addrs[2] = bnd - 1; addrs[3] = bnd;
            for (int i = 0; i < 4; i++) begin
                bit e;
                e = prot(n, addrs[i]);
                issue(3'd1, '0, 8'h00);
                issue((i % 2 == 0) ? 3'd4 : 3'd5, AW'(addrs[i]), 8'h00);
                chk(acc == !e && rej == e, "R8 range gate", {acc, rej}, e ? 1 : 2);
                if (acc) finish_op();
                chk(status_o == 8'(n << 2), "R11 status after range op", status_o, n << 2);
            end
            issue(3'd1, '0, 8'h00);
            issue(3'd6, '0, 8'h00);
            chk(acc == (n == 0) && rej == (n != 0), "R9 bulk erase gate", {acc, rej}, (n == 0) ? 2 : 1);
            if (acc) finish_op();
        end

        set_status(8'h00);
        otp_mode = 1'b1;
        set_status(8'h80);
        chk(status_o == 8'h80, "R10 lock set in OTP mode", status_o, 8'h80);
        for (int w = 0; w < 2; w++) begin
            wp_n = w[0];
            for (int c = 3; c <= 6; c++) begin
                issue(3'd1, '0, 8'h00);
                issue(3'(c), '0, 8'h00);
                chk(rej && status_o == 8'h80, "R10 OTP lock blocks", status_o, 8'h80);
            end
        end
        otp_mode = 1'b0;
        wp_n = 1'b1;
        set_status(8'h00);
        chk(status_o == 8'h00, "R7 pin high permits status write", status_o, 8'h00);

        issue(3'd7, '0, 8'h00);
        chk(rej && !acc, "R12 reserved code rejected", {acc, rej}, 1);

        issue(3'd1, '0, 8'h00);
        finish_op();
        chk(status_o == 8'h02, "R4 idle completion ignored", status_o, 8'h02);

        @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule